// File: doc/BRIEF.md
# FSK Tag Demodulator and Frame Decoder

This block takes a stream of 8-bit envelope samples from a low-frequency reader's converter and recovers tag identifiers. The tags use frequency-shift keying. Each sample is sliced to one bit. The distance between consecutive rising edges is measured, and each edge interval is labelled as a short cycle (fc/8) or a long cycle (fc/10).

Runs of equal labels are turned into Manchester half-bits by dividing each run length by a factor that depends on the label. A six-half-bit pattern that is not valid Manchester marks the start of each frame. The half-bit pairs that follow are decoded into data bits and shifted into an accumulator. The identifier collected so far is reported when the next start marker appears.

Samples arrive with a valid qualifier, so the block can sit behind any converter rate. Results leave as a one-cycle strobe that carries the identifier and a 16-bit sub-field taken from it.

Top module: `fskd_tag_demod`

## Requirements
- R1: A sample whose value is below 127 is read as low; a sample of 127 or more is read as high.
- R2: At every low-to-high transition, the number of samples since the previous transition is measured. An interval of 8 or fewer samples is a short cycle (class 1). A longer interval is a long cycle (class 0). The first transition after reset only starts the measurement.
- R3: When the class changes, the finished run of n cycles is converted. A run of short cycles gives (n+1)/6 and a run of long cycles gives (n+1)/5, both with integer division. A result of 0 or 1 emits one half-bit, and a result of 2, 3 or 4 emits that many half-bits. Every emitted half-bit carries the class value of the run.
- R4: A converted run length above 4 emits no half-bits.
- R5: The edge-interval count saturates at 255, so a long silence always reads as a long cycle.
- R6: The half-bit sequence 1,1,1,0,0,0 (oldest first) is a start marker. The marker is checked before pair decoding at every position, and it clears the accumulator and starts a new frame.
- R7: Inside a frame, the pair 1,0 decodes to data bit 0 and the pair 0,1 decodes to data bit 1. Each data bit shifts into the LSB of a 64-bit accumulator.
- R8: Any other pair (0,0 or 1,1) ends the frame and clears the accumulator.
- R9: When a start marker is found and the accumulator is non-zero, `id_valid` pulses for one cycle. `id` carries accumulator bits 43..0 and `id_field` carries accumulator bits 16..1.
- R10: A start marker found while the accumulator is zero reports nothing.
- R11: After reset, `id_valid`, `id` and `id_field` are all zero.
- R12: A cycle with `smp_valid` low changes no state, whatever `smp_data` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample qualifier |
| smp_data | input | 8 | Envelope sample |
| id_valid | output | 1 | One-cycle strobe for a decoded identifier |
| id | output | 44 | Identifier from the accumulator |
| id_field | output | 16 | Accumulator bits 16..1 |

## Verification
The hardest situations to reach are the ones where the run coder emits several half-bits in one cycle. In those cycles a start marker has to win over pair decoding, and an overlong run or a silent gap has to vanish without putting the pair alignment out of step. The bench therefore builds a real waveform cycle by cycle, from whole frames with several cycle periods, slicing levels and idle bubbles. Between frames it places long idle runs and a 260-sample silence. If either of these leaked a half-bit, the following frame would be cancelled, so the effect shows up at the identifier port.

// File: rtl/fskd_pkg.sv
package fskd_pkg;

    // Class of one measured carrier cycle
    typedef enum logic {
        CLS_FC10 = 1'b0,
        CLS_FC8  = 1'b1
    } cycle_cls_e;

    // Start-of-frame half-bit pattern, oldest half-bit in the MSB
    localparam int                 SOF_LEN     = 6;
    localparam logic [SOF_LEN-1:0] SOF_PATTERN = 6'b111000;

endpackage

// File: rtl/fskd_edge_meter.sv
module fskd_edge_meter
    import fskd_pkg::*;
#(
    parameter int SMP_W   = 8,
    parameter int THRESH  = 127,
    parameter int CNT_W   = 8,
    parameter int FC8_MAX = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    output logic             cls_valid,
    output cycle_cls_e       cls
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             level;
        logic             armed;
        logic [CNT_W-1:0] cnt;
        logic             cls_vld;
        cycle_cls_e       cls;
    } meter_t;

    meter_t           s_q, s_d;
    logic             lvl;
    logic [CNT_W-1:0] step;

    always_comb begin
        s_d         = s_q;
        s_d.cls_vld = 1'b0;
        lvl         = (smp_data >= SMP_W'(THRESH));
        step        = (s_q.cnt == CNT_MAX) ? CNT_MAX : s_q.cnt + 1'b1;
        if (smp_valid) begin
            if (lvl && !s_q.level) begin
                s_d.cls_vld = s_q.armed;
                s_d.cls     = (int'(step) <= FC8_MAX) ? CLS_FC8 : CLS_FC10;
                s_d.armed   = 1'b1;
                s_d.cnt     = '0;
            end else begin
                s_d.cnt = step;
            end
            s_d.level = lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cls_valid = s_q.cls_vld;
    assign cls       = s_q.cls;

    // R1: a low sample never produces an edge
    a_r1_low_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_data < SMP_W'(THRESH)) |=> !s_q.cls_vld);

    // R5: a saturated count stays saturated through further low samples
    a_r5_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == CNT_MAX && smp_valid && smp_data < SMP_W'(THRESH)) |=> s_q.cnt == CNT_MAX);

    // R12: an unqualified cycle changes neither level nor class output
    a_r12_bubble_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(s_q.level) && $stable(s_q.cnt) && !s_q.cls_vld));

endmodule

// File: rtl/fskd_run_coder.sv
module fskd_run_coder
    import fskd_pkg::*;
#(
    parameter int RUN_W    = 8,
    parameter int FC8_DIV  = 6,
    parameter int FC10_DIV = 5,
    parameter int MAX_HB   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cls_valid,
    input  cycle_cls_e                  cls,
    output logic                        hb_valid,
    output logic [$clog2(MAX_HB+1)-1:0] hb_count,
    output logic                        hb_value
);

    localparam int               HB_CW   = $clog2(MAX_HB + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    typedef struct packed {
        logic             started;
        cycle_cls_e       run_cls;
        logic [RUN_W-1:0] run_len;
        logic             hb_vld;
        logic [HB_CW-1:0] hb_cnt;
        logic             hb_val;
    } coder_t;

    coder_t         s_q, s_d;
    logic [RUN_W:0] len_p1;
    logic [RUN_W:0] conv;
    logic [HB_CW-1:0] emit;

    always_comb begin
        s_d        = s_q;
        s_d.hb_vld = 1'b0;
        len_p1     = {1'b0, s_q.run_len} + 1'b1;
        conv       = (s_q.run_cls == CLS_FC8) ? len_p1 / (RUN_W+1)'(FC8_DIV)
                                              : len_p1 / (RUN_W+1)'(FC10_DIV);
        if (conv <= 1)                emit = HB_CW'(1);
        else if (int'(conv) <= MAX_HB) emit = HB_CW'(conv);
        else                          emit = '0;

        if (cls_valid) begin
            if (!s_q.started) begin
                s_d.started = 1'b1;
                s_d.run_cls = cls;
                s_d.run_len = RUN_W'(1);
            end else if (cls == s_q.run_cls) begin
                s_d.run_len = (s_q.run_len == RUN_MAX) ? RUN_MAX : s_q.run_len + 1'b1;
            end else begin
                s_d.hb_vld  = (emit != '0);
                s_d.hb_cnt  = emit;
                s_d.hb_val  = (s_q.run_cls == CLS_FC8);
                s_d.run_cls = cls;
                s_d.run_len = RUN_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hb_valid = s_q.hb_vld;
    assign hb_count = s_q.hb_cnt;
    assign hb_value = s_q.hb_val;

    // R3 and R4: an emitted group holds between one and MAX_HB half-bits
    a_r4_group_size: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.hb_vld |-> (s_q.hb_cnt >= 1 && int'(s_q.hb_cnt) <= MAX_HB));

    // R3: groups come only from a class change, which needs a class input
    a_r3_group_needs_class: assert property (@(posedge clk) disable iff (!rst_n)
        !cls_valid |=> !s_q.hb_vld);

endmodule

// File: rtl/fskd_frame_decoder.sv
module fskd_frame_decoder
    import fskd_pkg::*;
#(
    parameter int ID_W    = 44,
    parameter int ACC_W   = 64,
    parameter int FIELD_W = 16,
    parameter int MAX_HB  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        hb_valid,
    input  logic [$clog2(MAX_HB+1)-1:0] hb_count,
    input  logic                        hb_value,
    output logic                        id_valid,
    output logic [ID_W-1:0]             id,
    output logic [FIELD_W-1:0]          id_field
);

    localparam int PEND_W = $clog2(SOF_LEN + 1);

    typedef struct packed {
        logic [SOF_LEN-1:0] win;
        logic [PEND_W-1:0]  pend;
        logic               found;
        logic [ACC_W-1:0]   acc;
        logic               rpt;
        logic [ID_W-1:0]    id;
        logic [FIELD_W-1:0] field;
    } dec_t;

    dec_t s_q, s_d;

    always_comb begin
        s_d     = s_q;
        s_d.rpt = 1'b0;
        for (int i = 0; i < MAX_HB; i++) begin
            if (hb_valid && i < int'(hb_count)) begin
                s_d.win  = {s_d.win[SOF_LEN-2:0], hb_value};
                s_d.pend = s_d.pend + 1'b1;
                if (s_d.pend == PEND_W'(SOF_LEN)) begin
                    if (s_d.win == SOF_PATTERN) begin
                        if (|s_d.acc) begin
                            s_d.rpt   = 1'b1;
                            s_d.id    = s_d.acc[ID_W-1:0];
                            s_d.field = s_d.acc[FIELD_W:1];
                        end
                        s_d.acc   = '0;
                        s_d.found = 1'b1;
                        s_d.pend  = '0;
                    end else if (s_d.found) begin
                        if (s_d.win[SOF_LEN-1] ^ s_d.win[SOF_LEN-2]) begin
                            s_d.acc = {s_d.acc[ACC_W-2:0], s_d.win[SOF_LEN-2]};
                        end else begin
                            s_d.found = 1'b0;
                            s_d.acc   = '0;
                        end
                        s_d.pend = PEND_W'(SOF_LEN - 2);
                    end else begin
                        s_d.pend = PEND_W'(SOF_LEN - 1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign id_valid = s_q.rpt;
    assign id       = s_q.id;
    assign id_field = s_q.field;

    // R8: outside a frame the accumulator is always empty
    a_r8_idle_acc_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.found |-> s_q.acc == '0);

    // R9: a report is a single-cycle strobe
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rpt |=> !s_q.rpt);

    // R6: a report always coincides with a freshly opened frame
    a_r6_open_on_report: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rpt |-> (s_q.found && s_q.acc == '0));

endmodule

// File: rtl/fskd_tag_demod.sv
module fskd_tag_demod
    import fskd_pkg::*;
#(
    parameter int SMP_W    = 8,
    parameter int THRESH   = 127,
    parameter int CNT_W    = 8,
    parameter int FC8_MAX  = 8,
    parameter int RUN_W    = 8,
    parameter int FC8_DIV  = 6,
    parameter int FC10_DIV = 5,
    parameter int MAX_HB   = 4,
    parameter int ID_W     = 44,
    parameter int ACC_W    = 64,
    parameter int FIELD_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_valid,
    input  logic [SMP_W-1:0]   smp_data,
    output logic               id_valid,
    output logic [ID_W-1:0]    id,
    output logic [FIELD_W-1:0] id_field
);

    localparam int HB_CW = $clog2(MAX_HB + 1);

    logic             cls_valid;
    cycle_cls_e       cls;
    logic             hb_valid;
    logic [HB_CW-1:0] hb_count;
    logic             hb_value;

    fskd_edge_meter #(
        .SMP_W   (SMP_W),
        .THRESH  (THRESH),
        .CNT_W   (CNT_W),
        .FC8_MAX (FC8_MAX)
    ) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .cls_valid (cls_valid),
        .cls       (cls)
    );

    fskd_run_coder #(
        .RUN_W    (RUN_W),
        .FC8_DIV  (FC8_DIV),
        .FC10_DIV (FC10_DIV),
        .MAX_HB   (MAX_HB)
    ) u_coder (
        .clk       (clk),
        .rst_n     (rst_n),
        .cls_valid (cls_valid),
        .cls       (cls),
        .hb_valid  (hb_valid),
        .hb_count  (hb_count),
        .hb_value  (hb_value)
    );

    fskd_frame_decoder #(
        .ID_W    (ID_W),
        .ACC_W   (ACC_W),
        .FIELD_W (FIELD_W),
        .MAX_HB  (MAX_HB)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .hb_valid (hb_valid),
        .hb_count (hb_count),
        .hb_value (hb_value),
        .id_valid (id_valid),
        .id       (id),
        .id_field (id_field)
    );

endmodule

// File: tb/sim_fskd_tag_demod.sv
`timescale 1ns/1ps
module sim_fskd_tag_demod;

    logic        clk;
    logic        rst_n;
    logic        smp_valid;
    logic [7:0]  smp_data;
    logic        id_valid;
    logic [43:0] id;
    logic [15:0] id_field;

    int n_chk = 0;
    int n_err = 0;

    fskd_tag_demod u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .id_valid  (id_valid),
        .id        (id),
        .id_field  (id_field)
    );

    initial begin
        clk = 1'b0;
        forever #5 clk = ~clk;
    end

    // Report capture, sampled away from the active edge
    logic [43:0] got_id [0:31];
    logic [15:0] got_f  [0:31];
    int          got_n = 0;
    always @(negedge clk) begin
        if (rst_n === 1'b1 && id_valid === 1'b1 && got_n < 32) begin
            got_id[got_n] = id;
            got_f[got_n]  = id_field;
            got_n         = got_n + 1;
        end
    end

    // Stimulus settings
    int         p8  = 8;
    int         p10 = 10;
    logic [7:0] lov = 8'd0;
    logic [7:0] hiv = 8'd255;
    bit         bub = 1'b0;

    // Frame table: id, short and long periods, slicing levels, bubbles
    localparam int NV = 5;
    localparam logic [43:0] V_ID  [NV] = '{44'h123_4567_89AB,  // plain frame
                                           44'hFFF_FFFF_FFFF,  // R1 levels 126/127
                                           44'h000_0000_0000,  // R10 empty, R2 period 9
                                           44'h800_0000_0001,  // R12 bubbles
                                           44'h0F0_F0F0_F0F1};
    localparam int          V_P8  [NV] = '{8, 7, 8, 6, 8};
    localparam int          V_P10 [NV] = '{10, 11, 9, 12, 10};
    localparam logic [7:0]  V_LO  [NV] = '{8'd0, 8'd126, 8'd20, 8'd0, 8'd60};
    localparam logic [7:0]  V_HI  [NV] = '{8'd255, 8'd127, 8'd200, 8'd240, 8'd180};
    localparam bit          V_BUB [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0};

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic put(input logic [7:0] v);
        if (bub) begin
            @(negedge clk);
            smp_valid = 1'b0;
            smp_data  = ~v;
        end
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = v;
    endtask

    task automatic cyc(input int period);
        put(hiv);
        put(hiv);
        for (int k = 2; k < period; k++) put(lov);
    endtask

    task automatic burst(input bit is8, input int n);
        for (int k = 0; k < n; k++) cyc(is8 ? p8 : p10);
    endtask

    task automatic send_marker();
        burst(1'b1, 18);
        burst(1'b0, 15);
        burst(1'b1, 6);
        burst(1'b0, 5);
    endtask

    task automatic send_bit(input bit b);
        if (b) begin burst(1'b0, 5); burst(1'b1, 6); end
        else   begin burst(1'b1, 6); burst(1'b0, 5); end
    endtask

    task automatic send_frame(input logic [43:0] v);
        send_marker();
        for (int i = 43; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_gap();
        put(hiv);
        put(hiv);
        for (int k = 0; k < 260; k++) put(lov);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        smp_valid = 1'b0;
        smp_data  = 8'h00;
        repeat (n) @(negedge clk);
    endtask

    task automatic normal();
        p8 = 8; p10 = 10; lov = 8'd0; hiv = 8'd255; bub = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n     = 1'b0;
        smp_valid = 1'b0;
        smp_data  = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int base;
        int k;
        logic [43:0] e_id;
        logic [43:0] f_id;
        rst_n     = 1'b0;
        smp_valid = 1'b0;
        smp_data  = 8'h00;
        normal();
        do_reset();

        // R11: reset state
        chk("R11 id_valid after reset", 64'(id_valid), 64'd0);
        chk("R11 id after reset", 64'(id), 64'd0);
        chk("R11 id_field after reset", 64'(id_field), 64'd0);

        // Table walk: R1 R2 R3 R6 R7 R9 R10 R12
        base = got_n;
        for (int v = 0; v < NV; v++) begin
            p8 = V_P8[v]; p10 = V_P10[v]; lov = V_LO[v]; hiv = V_HI[v]; bub = V_BUB[v];
            send_frame(V_ID[v]);
        end
        normal();
        send_frame(44'h1);
        idle(20);
        k = 0;
        for (int v = 0; v < NV; v++) begin
            if (V_ID[v] != 44'h0) begin
                chk($sformatf("R1 R2 R3 R6 R7 R9 R12 vector %0d id", v),
                    64'(got_id[base+k]), 64'(V_ID[v]));
                chk($sformatf("R9 vector %0d field", v),
                    64'(got_f[base+k]), 64'(V_ID[v][16:1]));
                k++;
            end
        end
        chk("R10 report count for table", 64'(got_n - base), 64'(k));

        // R8: a bad pair cancels the frame and empties the accumulator
        do_reset();
        base = got_n;
        f_id = 44'h0AB_CDEF_0123;
        send_marker();
        for (int j = 0; j < 4; j++) send_bit(1'b1);
        burst(1'b0, 10);
        send_frame(f_id);
        send_frame(44'h1);
        idle(20);
        chk("R8 report count after cancel", 64'(got_n - base), 64'd1);
        chk("R8 id after cancel", 64'(got_id[base]), 64'(f_id));

        // R4: an overlong run between frames emits nothing
        do_reset();
        base = got_n;
        e_id = 44'h5A5_A5A5_A5A5;
        f_id = 44'h3C3_C3C3_3C3C;
        send_frame(e_id);
        burst(1'b0, 40);
        send_frame(f_id);
        send_frame(44'h1);
        idle(20);
        chk("R4 report count with long run", 64'(got_n - base), 64'd2);
        chk("R4 first id", 64'(got_id[base]), 64'(e_id));
        chk("R4 second id", 64'(got_id[base+1]), 64'(f_id));

        // R5: a 262-sample interval saturates and reads as a long cycle
        do_reset();
        base = got_n;
        send_frame(e_id);
        burst(1'b0, 20);
        send_gap();
        burst(1'b0, 20);
        send_frame(44'h1);
        idle(20);
        chk("R5 report count across silence", 64'(got_n - base), 64'd1);
        chk("R5 id across silence", 64'(got_id[base]), 64'(e_id));

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule